// File: doc/BRIEF.md
# Host Port Status and Change-Flag Register

This block holds the status and control word for one host-side port of a full-speed serial bus controller. Hardware event inputs drive it: attach and detach pulses, a reset-complete pulse and a level-sensitive overcurrent input. From these it keeps three live status bits: device present, port enabled and overcurrent active. It also keeps three sticky change flags. Software clears a flag by writing 1 to its bit. The flags feed a single port interrupt, and each flag has its own enable input.

The enable bit has an unusual access rule. Only hardware can turn it on, and only when a reset sequence finishes on a connected port. Software can only turn it off, by writing 1 to it. Hardware also turns it off on a detach or on overcurrent. The register is read as a continuous word. A write is one strobe with a data word, and the strobe carries no address.

Top module: `hps_port_reg`

## Requirements
- R1: After reset every bit of `reg_rdata` is 0 and `port_irq` is 0.
- R2: Bit 0 (device present) becomes 1 one cycle after an `ev_attach` pulse. It becomes 0 one cycle after an `ev_detach` pulse. When both pulses arrive in the same cycle, the detach wins.
- R3: Bit 1 (attach seen) is set one cycle after `ev_attach`. A write with data bit 1 at 1 clears it. A write with data bit 1 at 0 leaves it unchanged, and no write can set it.
- R4: Bit 2 (port enabled) becomes 1 only one cycle after `ev_rst_done`, and only if bit 0 is already 1 and no disable condition is present in that cycle. No write ever sets it.
- R5: Bit 2 becomes 0 one cycle after any of these: an `ev_detach` pulse, `oc_in` at 1, or a write with data bit 2 at 1. A disable condition takes priority over a reset-complete pulse in the same cycle. Writing 0 to bit 2 has no effect.
- R6: Bit 3 (enable changed) is set in the same cycle that bit 2 takes a new value, whatever caused the change. A write with data bit 3 at 1 clears it.
- R7: Bit 4 (overcurrent active) equals the value `oc_in` had on the previous clock edge.
- R8: Bit 5 (overcurrent changed) is set in the same cycle that bit 4 takes a new value. A write with data bit 5 at 1 clears it.
- R9: When a set event and a write-1 clear reach the same flag (bit 1, 3 or 5) in the same cycle, the flag ends at 1.
- R10: A write with data bit 2 at 1 while bit 2 is 0 changes nothing. Bit 3 is not set by it.
- R11: `port_irq` = (bit1 & irq_en[0]) | (bit3 & irq_en[1]) | (bit5 & irq_en[2]). It is combinational from the register, and bit 2 on its own never raises it.
- R12: Writes never change bits 0 and 4. Bits 6 and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | DATA_W | Write data; a 1 in bit 1, 2, 3 or 5 clears that bit |
| reg_rdata | output | DATA_W | Current register contents |
| ev_attach | input | 1 | One-cycle pulse: a device was attached |
| ev_detach | input | 1 | One-cycle pulse: the device was removed |
| ev_rst_done | input | 1 | One-cycle pulse: the port reset sequence finished |
| oc_in | input | 1 | Overcurrent condition level |
| irq_en | input | 3 | Interrupt enables for bits 1, 3 and 5 |
| port_irq | output | 1 | Port interrupt |

## Verification
Several things can land on one edge: a set event, a write-1 clear of the same flag, and an enable change caused by overcurrent or detach arriving with a reset-complete pulse. These cases are hard to reach from the ports, because each one needs the flag to be already set and the port to be already enabled when the events meet. A directed prefix builds exactly these states and then fires the colliding inputs together. After that, a long pseudo-random sweep covers every input combination, and a model in the bench, written from the requirements, checks each cycle. The bench keeps the overcurrent level sticky and makes detach rare, so that the enabled state lasts long enough to meet writes and faults.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int BIT_CONN = 0;
  localparam int BIT_CDET = 1;
  localparam int BIT_EN   = 2;
  localparam int BIT_ECHG = 3;
  localparam int BIT_OCA  = 4;
  localparam int BIT_OCHG = 5;
  localparam int NUM_FLAGS = 3;
  localparam int USED_BITS = 6;

  typedef struct packed {
    logic conn;
    logic en;
    logic oc;
  } port_state_t;

  // sticky flag i lives at bit 2*i+1
  function automatic int flag_bit(input int idx);
    return 2 * idx + 1;
  endfunction
endpackage

// File: rtl/hps_flag.sv
module hps_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;   // a set beats a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r3_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/hps_state.sv
module hps_state
  import hps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        attach_i,
  input  logic        detach_i,
  input  logic        rst_done_i,
  input  logic        oc_i,
  input  logic        sw_disable_i,
  output port_state_t st_o,
  output logic        en_changed_o,
  output logic        oc_changed_o
);
  port_state_t st_d;
  logic        en_clr;
  logic        en_set;

  always_comb begin
    en_clr = detach_i | oc_i | sw_disable_i;
    en_set = rst_done_i & st_o.conn;
    st_d   = st_o;
    if (attach_i)    st_d.conn = 1'b1;
    if (detach_i)    st_d.conn = 1'b0;
    if (en_set)      st_d.en   = 1'b1;
    if (en_clr)      st_d.en   = 1'b0;
    st_d.oc = oc_i;
    en_changed_o = st_d.en ^ st_o.en;
    oc_changed_o = st_d.oc ^ st_o.oc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_o <= '0;
    else        st_o <= st_d;
  end

  a_r2_detach_drops: assert property (@(posedge clk) disable iff (!rst_n)
    detach_i |=> !st_o.conn);
  a_r2_attach_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (attach_i && !detach_i) |=> st_o.conn);
  a_r4_en_only_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_o.en && !rst_done_i) |=> !st_o.en);
  a_r5_en_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (detach_i || oc_i || sw_disable_i) |=> !st_o.en);
  a_r7_oc_high: assert property (@(posedge clk) disable iff (!rst_n)
    oc_i |=> st_o.oc);
  a_r7_oc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_i |=> !st_o.oc);
endmodule

// File: rtl/hps_port_reg.sv
module hps_port_reg
  import hps_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_attach,
  input  logic              ev_detach,
  input  logic              ev_rst_done,
  input  logic              oc_in,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic              port_irq
);
  localparam int PAD_W = DATA_W - USED_BITS;

  port_state_t          st;
  logic                 en_chg;
  logic                 oc_chg;
  logic                 sw_disable;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign sw_disable   = reg_wr & reg_wdata[BIT_EN];

  hps_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .attach_i     (ev_attach),
    .detach_i     (ev_detach),
    .rst_done_i   (ev_rst_done),
    .oc_i         (oc_in),
    .sw_disable_i (sw_disable),
    .st_o         (st),
    .en_changed_o (en_chg),
    .oc_changed_o (oc_chg)
  );

  assign flag_set = {oc_chg, en_chg, ev_attach};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flag_clr[i] = reg_wr & reg_wdata[flag_bit(i)];
    hps_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .q_o   (flag_q[i])
    );
  end

  always_comb begin
    reg_rdata = {{PAD_W{1'b0}}, {USED_BITS{1'b0}}};
    reg_rdata[BIT_CONN] = st.conn;
    reg_rdata[BIT_EN]   = st.en;
    reg_rdata[BIT_OCA]  = st.oc;
    for (int i = 0; i < NUM_FLAGS; i++) reg_rdata[flag_bit(i)] = flag_q[i];
  end

  assign port_irq = |(flag_q & irq_en);

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !port_irq);
  a_r6_en_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[BIT_EN] != $past(reg_rdata[BIT_EN])) |-> reg_rdata[BIT_ECHG]);
  a_r8_oc_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[BIT_OCA] != $past(reg_rdata[BIT_OCA])) |-> reg_rdata[BIT_OCHG]);
  a_r12_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:USED_BITS] == '0);
endmodule

// File: tb/sim_hps_port_reg.sv
module sim_hps_port_reg;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         ev_attach = 1'b0, ev_detach = 1'b0, ev_rst_done = 1'b0, oc_in = 1'b0;
  logic [2:0]   irq_en = 3'b000;
  logic         port_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  logic m_c = 0, m_cd = 0, m_en = 0, m_ec = 0, m_o = 0, m_oh = 0;

  always #2.5 clk = ~clk;

  hps_port_reg #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_attach(ev_attach), .ev_detach(ev_detach),
    .ev_rst_done(ev_rst_done), .oc_in(oc_in), .irq_en(irq_en), .port_irq(port_irq)
  );

  function automatic string req_of(input int b);
    case (b)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [W-1:0] e;
    logic ei;
    e = '0;
    e[0] = m_c; e[1] = m_cd; e[2] = m_en; e[3] = m_ec; e[4] = m_o; e[5] = m_oh;
    ei = (m_cd & irq_en[0]) | (m_ec & irq_en[1]) | (m_oh & irq_en[2]);
    total++;
    if (reg_rdata !== e) begin
      bad++;
      for (int b = 0; b < W; b++)
        if (reg_rdata[b] !== e[b]) begin
          $display("FAIL %s %s bit%0d actual=%h expected=%h", req_of(b), tag, b, reg_rdata, e);
          break;
        end
    end
    chk(port_irq === ei, "R11", {tag, " irq"}, {31'b0, port_irq}, {31'b0, ei});
  endtask

  // drive one cycle of inputs, advance model, wait for result
  task automatic cyc(input bit a, input bit d, input bit r, input bit o,
                     input bit w, input logic [W-1:0] wd, input logic [2:0] ie);
    logic clr, n_en, n_o;
    ev_attach = a; ev_detach = d; ev_rst_done = r; oc_in = o;
    reg_wr = w; reg_wdata = wd; irq_en = ie;
    clr  = d | o | (w & wd[2]);
    n_en = clr ? 1'b0 : ((r & m_c) ? 1'b1 : m_en);
    n_o  = o;
    m_ec = (n_en != m_en) ? 1'b1 : ((w & wd[3]) ? 1'b0 : m_ec);
    m_oh = (n_o != m_o) ? 1'b1 : ((w & wd[5]) ? 1'b0 : m_oh);
    m_cd = a ? 1'b1 : ((w & wd[1]) ? 1'b0 : m_cd);
    m_c  = d ? 1'b0 : (a ? 1'b1 : m_c);
    m_en = n_en;
    m_o  = n_o;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    bit oc_lvl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_rdata === '0, "R1", "reset reg", reg_rdata, '0);
    chk(port_irq === 1'b0, "R1", "reset irq", {31'b0, port_irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R3 write 1 to clear bit when zero cannot set; no effect
    cyc(0,0,0,0,1,32'h3F,3'b111); compare_all("R3 write ones idle");
    chk(reg_rdata === '0, "R12", "writes leave status", reg_rdata, '0);
    // R4 reset-complete without device: no enable
    cyc(0,0,1,0,0,'0,3'b111); compare_all("R4 rst_done unconnected");
    // attach -> bit0, bit1, irq
    cyc(1,0,0,0,0,'0,3'b001); compare_all("R2 attach");
    chk(port_irq === 1'b1, "R11", "attach irq", {31'b0, port_irq}, 32'd1);
    // R11 enable masks
    cyc(0,0,0,0,0,'0,3'b110); compare_all("R11 masked");
    // R3 write 0 no effect
    cyc(0,0,0,0,1,32'h0,3'b111); compare_all("R3 write zero");
    // R9 attach and clear same cycle
    cyc(1,0,0,0,1,32'h2,3'b111); compare_all("R9 set beats clear");
    chk(reg_rdata[1] === 1'b1, "R9", "attach flag", {31'b0, reg_rdata[1]}, 32'd1);
    // R4 enable after reset on connected port
    cyc(0,0,1,0,0,'0,3'b000); compare_all("R4 enable");
    chk(reg_rdata[2] === 1'b1, "R4", "enabled", {31'b0, reg_rdata[2]}, 32'd1);
    // R11 bit2 alone never raises irq
    cyc(0,0,0,0,1,32'h0A,3'b111); compare_all("R11 enable only");
    chk(port_irq === 1'b0, "R11", "enable alone", {31'b0, port_irq}, '0);
    // R5 writing 0 to bit2 keeps it
    cyc(0,0,0,0,1,32'h0,3'b111); compare_all("R5 write zero en");
    // R9 en change collides with clear of bit3
    cyc(0,0,0,0,1,32'h0C,3'b111); compare_all("R9 sw disable with clear");
    chk(reg_rdata[3:2] === 2'b10, "R9", "echg kept", {30'b0, reg_rdata[3:2]}, 32'd2);
    cyc(0,0,0,0,1,32'h08,3'b111); compare_all("R6 clear echg");
    // R10 write bit2 while disabled
    cyc(0,0,0,0,1,32'h04,3'b111); compare_all("R10 disabled write");
    chk(reg_rdata[3] === 1'b0, "R10", "no echg", {31'b0, reg_rdata[3]}, '0);
    // re-enable, then overcurrent coincides with rst_done
    cyc(0,0,1,0,0,'0,3'b111); compare_all("R4 re-enable");
    cyc(0,0,1,1,1,32'h08,3'b111); compare_all("R5 oc beats rst_done");
    chk(reg_rdata[5:2] === 4'b1110, "R8", "oc flags", {28'b0, reg_rdata[5:2]}, 32'hE);
    cyc(0,0,0,0,1,32'h20,3'b111); compare_all("R8 oc drop with clear");
    // R2 attach and detach together
    cyc(1,1,0,0,0,'0,3'b111); compare_all("R2 detach wins");
    chk(reg_rdata[0] === 1'b0, "R2", "conn", {31'b0, reg_rdata[0]}, '0);

    // sweep
    lf = 32'hACE1_1234;
    oc_lvl = 1'b0;
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[13:11] == 3'b000) oc_lvl = ~oc_lvl;
      cyc(lf[2:0] == 3'b000, lf[7:3] == 5'b00000, lf[8] & lf[9], oc_lvl,
          lf[14] & lf[15], {lf[15:0], lf[31:16]}, lf[26:24]);
      compare_all("sweep");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule